// File: doc/BRIEF.md
# Watchdog Reset Timer with Fuse-Selected Write Protection

This block is a watchdog that counts ticks from a slow free-running oscillator, delivered as a one-cycle enable pulse in the system clock domain. Software must service it by pulsing `kick` before the selected time-out elapses. When the time-out is reached with no service, the block raises a one-cycle reset request for the chip's reset controller. A 3-bit period code selects one of eight time-outs. Each step of the code doubles the time-out, starting from 2^BASE_LOG2 ticks.

Two fuse inputs fix how well the configuration is guarded against stray software writes. At the open level the enable and period take any write directly. At the guarded level software may always turn the watchdog on. Turning it off or changing the period needs an unlock write followed by the real write within a short window. At the locked level the watchdog always runs, and only the period can change, again only through the unlock window.

Top module: `wdt_guard`

## Requirements
- R1: After `rst_n` is released, `wdt_rst` is 0, `cur_per` is 0, and `cur_ena` is 0 unless the fuses select the locked level.
- R2: With the watchdog running and no kick, `wdt_rst` goes high in the cycle after the edge that samples the 2^(BASE_LOG2+cur_per)-th `osc_tick` counted from the last clear.
- R3: The time-out counter advances only on cycles where `osc_tick` is 1. With no ticks, no reset is requested however long the wait.
- R4: A `kick` clears the counter. A kick in the same cycle as the terminal tick wins, and no reset is requested for that period.
- R5: While `cur_ena` is 0 the counter is held at zero and `wdt_rst` stays 0.
- R6: After a reset request the counter restarts from zero, so a second request follows one full period later.
- R7: Fuse code 2'b01 (open level): a write (`wr_en`=1) loads `wr_ena` and `wr_per` directly.
- R8: Fuse code 2'b00 (guarded level): outside the unlock window, a write with `wr_ena`=1 sets the enable, while clearing the enable and changing the period are ignored.
- R9: At the guarded and locked levels, a write with `wr_chg`=1 and `wr_ena`=1 outside the window opens a window of WIN_CYC system clocks. A write in any of the next WIN_CYC cycles loads enable and period and closes the window. A write after that is treated as unguarded (R8).
- R10: Fuse bit 1 = 1 (locked level): `cur_ena` reads 1 at all times and the watchdog runs. The period changes only through the R9 window, and writing `wr_ena`=0 never stops it.
- R11: `wdt_rst` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| osc_tick | input | 1 | One-cycle pulse per watchdog oscillator period |
| kick | input | 1 | Service request; clears the counter |
| fuse_lvl | input | 2 | Safety level fuses: bit1=1 locked, 2'b01 open, 2'b00 guarded |
| wr_en | input | 1 | Configuration write strobe |
| wr_chg | input | 1 | Change-enable bit of the write |
| wr_ena | input | 1 | Enable bit of the write |
| wr_per | input | SEL_W | Period code of the write |
| wdt_rst | output | 1 | One-cycle system reset request |
| cur_ena | output | 1 | Effective enable readback |
| cur_per | output | SEL_W | Current period code readback |

## Verification
The time-out is driven with a tick on every cycle, a tick on every fourth cycle, and no ticks at all. These patterns separate counting of ticks from counting of clocks. Kicks land both mid-period and on the exact terminal tick, to show the kick taking priority. Several period codes, including the longest, confirm the doubling rule. Writes at each safety level are made with and without the unlock step, and on the last cycle inside the window and the first cycle outside it, to pin down the window length.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

   typedef enum logic [1:0] {
      LVL_OPEN    = 2'd0,
      LVL_GUARDED = 2'd1,
      LVL_LOCKED  = 2'd2
   } wdt_lvl_e;

   // fuse bit 1 forces the locked level; otherwise bit 0 opens the registers
   function automatic wdt_lvl_e fuse_to_lvl(input logic [1:0] fuse);
      if (fuse[1])      return LVL_LOCKED;
      else if (fuse[0]) return LVL_OPEN;
      else              return LVL_GUARDED;
   endfunction

endpackage

// File: rtl/wdt_cfg_guard.sv
module wdt_cfg_guard
   import wdt_guard_pkg::*;
#(
   parameter int SEL_W   = 3,
   parameter int WIN_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wdt_lvl_e         lvl,
   input  logic             wr_en,
   input  logic             wr_chg,
   input  logic             wr_ena,
   input  logic [SEL_W-1:0] wr_per,
   output logic             ena_eff,
   output logic [SEL_W-1:0] per
);
   localparam int WIN_W = $clog2(WIN_CYC + 1);

   logic             ena_q, ena_d;
   logic [SEL_W-1:0] per_q, per_d;
   logic [WIN_W-1:0] win_q, win_d;
   logic             win_open;

   assign win_open = (win_q != '0);

   always_comb begin
      ena_d = ena_q;
      per_d = per_q;
      win_d = win_open ? win_q - WIN_W'(1) : '0;
      if (wr_en) begin
         if (lvl == LVL_OPEN || win_open) begin
            ena_d = wr_ena;
            per_d = wr_per;
            win_d = '0;
         end else begin
            if (wr_ena) ena_d = 1'b1;
            if (wr_chg && wr_ena) win_d = WIN_W'(WIN_CYC);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q <= 1'b0;
         per_q <= '0;
         win_q <= '0;
      end else begin
         ena_q <= ena_d;
         per_q <= per_d;
         win_q <= win_d;
      end
   end

   assign ena_eff = ena_q | (lvl == LVL_LOCKED);
   assign per     = per_q;

   // R8, R10: no period change by a guarded write outside the window
   a_r8_period_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lvl != LVL_OPEN && !win_open) |=> $stable(per_q));

   // R8: a guarded write outside the window cannot clear the enable
   a_r8_no_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl != LVL_OPEN && !win_open && ena_q) |=> ena_q);

   // R9: the open window shrinks by one per idle cycle
   a_r9_window_count: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open && !wr_en) |=> (win_q == $past(win_q) - WIN_W'(1)));

   // R9: a write inside the window closes it
   a_r9_window_close: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open && wr_en) |=> !win_open);

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int BASE_LOG2 = 14,
   parameter int SEL_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   input  logic             kick,
   input  logic             ena,
   input  logic [SEL_W-1:0] per,
   output logic             fire
);
   localparam int NPER  = 1 << SEL_W;
   localparam int CNT_W = BASE_LOG2 + NPER - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [NPER-1:0]  hit;
   logic             term;
   logic             fire_q;

   // one terminal comparator per selectable period
   for (genvar g = 0; g < NPER; g++) begin : g_lim
      localparam logic [CNT_W-1:0] LIM_M1 =
         CNT_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
      assign hit[g] = (cnt_q >= LIM_M1);
   end

   assign term = osc_tick && hit[per];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else begin
         fire_q <= ena && !kick && term;
         if (!ena || kick)  cnt_q <= '0;
         else if (term)     cnt_q <= '0;
         else if (osc_tick) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign fire = fire_q;

   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fire_q |=> !fire_q);

   a_r4_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !fire_q);

   a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ena |=> (!fire_q && cnt_q == '0));

   a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_tick && !kick && ena) |=> $stable(cnt_q));

   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      fire_q |-> (cnt_q == '0));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdt_guard_pkg::*;
#(
   parameter int BASE_LOG2 = 14,
   parameter int SEL_W     = 3,
   parameter int WIN_CYC   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   input  logic             kick,
   input  logic [1:0]       fuse_lvl,
   input  logic             wr_en,
   input  logic             wr_chg,
   input  logic             wr_ena,
   input  logic [SEL_W-1:0] wr_per,
   output logic             wdt_rst,
   output logic             cur_ena,
   output logic [SEL_W-1:0] cur_per
);
   initial begin
      if (BASE_LOG2 < 1 || BASE_LOG2 + (1 << SEL_W) > 48)
         $fatal(1, "wdt_guard: BASE_LOG2/SEL_W out of range");
      if (SEL_W < 1 || SEL_W > 4)
         $fatal(1, "wdt_guard: SEL_W must be 1..4");
      if (WIN_CYC < 1)
         $fatal(1, "wdt_guard: WIN_CYC must be at least 1");
   end

   wdt_lvl_e         lvl;
   logic             ena_eff;
   logic [SEL_W-1:0] per;

   assign lvl = fuse_to_lvl(fuse_lvl);

   wdt_cfg_guard #(.SEL_W(SEL_W), .WIN_CYC(WIN_CYC)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl),
      .wr_en   (wr_en),
      .wr_chg  (wr_chg),
      .wr_ena  (wr_ena),
      .wr_per  (wr_per),
      .ena_eff (ena_eff),
      .per     (per)
   );

   wdt_count #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .kick     (kick),
      .ena      (ena_eff),
      .per      (per),
      .fire     (wdt_rst)
   );

   assign cur_ena = ena_eff;
   assign cur_per = per;

   // R10: the locked level always reports a running watchdog
   a_r10_locked_on: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_lvl[1] |-> cur_ena);

endmodule

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;
   localparam int BASE = 4;
   localparam int SW   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          osc_tick = 1'b0, kick = 1'b0;
   logic [1:0]    fuse_lvl = 2'b01;
   logic          wr_en = 1'b0, wr_chg = 1'b0, wr_ena = 1'b0;
   logic [SW-1:0] wr_per = '0;
   logic          wdt_rst, cur_ena;
   logic [SW-1:0] cur_per;

   int errors = 0, checks = 0, pulses = 0, cycles = 0;
   int tick_div = 1, tdiv = 0;

   // reference model state
   int m_ena = 0, m_per = 0, m_win = 0, m_cnt = 0, m_rst = 0;

   always #5 clk = ~clk;

   wdt_guard #(.BASE_LOG2(BASE), .SEL_W(SW), .WIN_CYC(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .kick(kick),
      .fuse_lvl(fuse_lvl), .wr_en(wr_en), .wr_chg(wr_chg), .wr_ena(wr_ena),
      .wr_per(wr_per), .wdt_rst(wdt_rst), .cur_ena(cur_ena), .cur_per(cur_per)
   );

   function automatic int lvl_of(input logic [1:0] f);
      if (f[1]) return 2;
      if (f[0]) return 0;
      return 1;
   endfunction

   function automatic int eff_ena();
      return (lvl_of(fuse_lvl) == 2) ? 1 : m_ena;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ena = 0; m_per = 0; m_win = 0; m_cnt = 0; m_rst = 0;
      end else begin
         int lv, en, ne, np, nw;
         lv = lvl_of(fuse_lvl);
         en = eff_ena();
         ne = m_ena; np = m_per;
         nw = (m_win > 0) ? m_win - 1 : 0;
         if (wr_en) begin
            if (lv == 0 || m_win > 0) begin
               ne = int'(wr_ena); np = int'(wr_per); nw = 0;
            end else begin
               if (wr_ena) ne = 1;
               if (wr_chg && wr_ena) nw = 4;
            end
         end
         m_rst = 0;
         if (en == 0 || kick) m_cnt = 0;
         else if (osc_tick) begin
            if (m_cnt + 1 >= (1 << (BASE + m_per))) begin
               m_cnt = 0; m_rst = 1;
            end else m_cnt = m_cnt + 1;
         end
         m_ena = ne; m_per = np; m_win = nw;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison with the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 wdt_rst vs model", int'(wdt_rst), m_rst);
         chk("R8 cur_ena vs model", int'(cur_ena), eff_ena());
         chk("R9 cur_per vs model", int'(cur_per), m_per);
         if (wdt_rst) pulses++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic cyc(input logic k, input logic w, input logic c,
                      input logic e, input logic [SW-1:0] p);
      @(negedge clk);
      kick = k; wr_en = w; wr_chg = c; wr_ena = e; wr_per = p;
      if (tick_div == 0) osc_tick = 1'b0;
      else begin
         osc_tick = (tdiv == 0);
         tdiv = (tdiv + 1) % tick_div;
      end
      @(posedge clk); #2;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '0);
   endtask

   task automatic count_over(input int n, input int exp, input string tag);
      int p0;
      p0 = pulses;
      idle(n);
      @(negedge clk); #1;
      chk(tag, pulses - p0, exp);
   endtask

   initial begin
      fuse_lvl = 2'b01;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      idle(1);
      chk("R1 wdt_rst after reset", int'(wdt_rst), 0);
      chk("R1 cur_ena after reset", int'(cur_ena), 0);
      chk("R1 cur_per after reset", int'(cur_per), 0);

      // open level: direct write, period code 0 = 16 ticks
      cyc(0, 1, 0, 1, 3'd0);
      chk("R7 direct enable", int'(cur_ena), 1);
      idle(15);
      chk("R2 no reset before period", int'(wdt_rst), 0);
      idle(1);
      chk("R2 reset at period end", int'(wdt_rst), 1);
      idle(1);
      chk("R11 pulse one cycle", int'(wdt_rst), 0);
      idle(15);
      chk("R6 second request one period later", int'(wdt_rst), 1);
      idle(15);
      cyc(1, 0, 0, 0, '0);
      chk("R4 kick on terminal tick wins", int'(wdt_rst), 0);
      idle(15);
      chk("R4 counter cleared by kick", int'(wdt_rst), 0);
      idle(1);
      chk("R4 request one period after kick", int'(wdt_rst), 1);

      // tick pattern: every fourth cycle, then none
      tick_div = 4; tdiv = 0;
      cyc(1, 0, 0, 0, '0);
      count_over(100, 1, "R3 slow ticks stretch the period");
      tick_div = 0;
      cyc(1, 0, 0, 0, '0);
      count_over(300, 0, "R3 no ticks no reset");
      tick_div = 1;

      // longer periods
      cyc(0, 1, 0, 1, 3'd3);
      cyc(1, 0, 0, 0, '0);
      count_over(300, 2, "R2 code 3 = 128 ticks");
      cyc(0, 1, 0, 1, 3'd7);
      cyc(1, 0, 0, 0, '0);
      count_over(2100, 1, "R2 code 7 = 2048 ticks");

      // disable at open level
      cyc(0, 1, 0, 0, 3'd0);
      chk("R5 disabled readback", int'(cur_ena), 0);
      count_over(200, 0, "R5 disabled never fires");

      // guarded level
      fuse_lvl = 2'b00;
      cyc(0, 1, 0, 1, 3'd1);
      chk("R8 enable allowed", int'(cur_ena), 1);
      chk("R8 period unchanged", int'(cur_per), 0);
      cyc(0, 1, 0, 0, 3'd3);
      chk("R8 disable ignored", int'(cur_ena), 1);
      chk("R8 period write ignored", int'(cur_per), 0);
      cyc(0, 1, 1, 1, 3'd0);
      idle(3);
      cyc(0, 1, 0, 1, 3'd5);
      chk("R9 last window cycle accepted", int'(cur_per), 5);
      cyc(0, 1, 1, 1, 3'd0);
      idle(4);
      cyc(0, 1, 0, 1, 3'd2);
      chk("R9 write after window ignored", int'(cur_per), 5);
      cyc(0, 1, 1, 1, 3'd0);
      cyc(0, 1, 0, 0, 3'd1);
      chk("R9 sequence disables", int'(cur_ena), 0);
      chk("R9 sequence sets period", int'(cur_per), 1);

      // locked level
      fuse_lvl = 2'b10;
      cyc(0, 0, 0, 0, '0);
      chk("R10 locked reads enabled", int'(cur_ena), 1);
      cyc(0, 1, 0, 0, 3'd0);
      chk("R10 period write ignored", int'(cur_per), 1);
      cyc(0, 1, 1, 1, 3'd0);
      cyc(0, 1, 0, 0, 3'd0);
      chk("R10 period via sequence", int'(cur_per), 0);
      chk("R10 still enabled", int'(cur_ena), 1);
      cyc(1, 0, 0, 0, '0);
      count_over(40, 2, "R10 locked watchdog runs");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule